// File: doc/BRIEF.md
# DRAM Bank Row-State Tracker

This block is the shadow model that a DRAM controller keeps of its devices' row buffers. For each of a fixed set of banks it remembers whether a row is open, which row that is, and whether it has been written since it was opened. From this record it tells the controller, before a request is sent, whether the access will hit the open row. On a miss it also tells the controller how many cycles to wait before sending the request again. The wait is longer when the row being closed is dirty, because that row must first be written back to the array.

When the controller issues a request, the tracker updates its record. A miss opens the new row clean and starts a per-bank wait counter. While that counter runs, the bank reports busy and the tracker ignores further requests to it. Every NAck that comes back is checked against the misses the tracker predicted. A NAck it did not predict sets a sticky error flag. The valid and dirty bits of all banks are presented side by side as a status word. A status write clears that word and the error flag.

By default eight 1 MiB banks are tracked, occupying the lowest 8 MiB of a 26-bit address space. The bank index is taken from the address bits starting at bit 20, the row from bits [19:11], and bits [10:0] select a column that plays no part in tracking. Addresses above the tracked region get no prediction and change no state.

Top module: `bank_row_tracker`

## Requirements
- R1: After reset, every bank's valid and dirty bits read 0, the error flag reads 0 and no bank is busy.
- R2: For a tracked address the bank index is addr[22:20] and the row is addr[19:11]; addresses that differ only in addr[10:0] fall in the same row.
- R3: A request to a valid bank whose open row equals the request row predicts pred_hit=1 with pred_wait=0.
- R4: A request to an invalid bank, or to another row of a valid clean bank, predicts pred_hit=0 with pred_wait=CLEAN_WAIT. Issuing it makes that bank valid with the new row and dirty 0.
- R5: A request to another row of a valid dirty bank predicts pred_hit=0 with pred_wait=DIRTY_WAIT.
- R6: An issued write that hits sets the bank's dirty bit; an issued read that hits leaves it unchanged.
- R7: After an issued miss, bank_busy for that bank is 1 for exactly pred_wait cycles and then 0.
- R8: A request issued to a busy bank is ignored: its row, valid and dirty bits are unchanged.
- R9: An address at or above NUM_BANKS MiB gives pred_tracked=0, pred_hit=0, pred_wait=0 and bank_busy=0, and issuing it changes no state.
- R10: A NAck (resp_ack=0) for a tracked bank with a predicted miss not yet answered leaves err_nack unchanged and consumes the prediction. Any other NAck, including one for an untracked address, sets err_nack, which then stays set. An Ack never sets it.
- R11: A status write clears all valid bits, all dirty bits and err_nack on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request issued to the devices this cycle |
| req_write | input | 1 | Request is a write |
| req_addr | input | ADDR_W | Request byte address |
| pred_tracked | output | 1 | Request address lies in a tracked bank |
| pred_hit | output | 1 | Request is predicted to hit the open row |
| pred_wait | output | WAIT_W | Cycles to wait before resending on a predicted miss |
| bank_busy | output | 1 | The request's bank is still opening a row |
| resp_valid | input | 1 | A response packet arrived |
| resp_ack | input | 1 | 1 for Ack, 0 for NAck |
| resp_addr | input | ADDR_W | Address of the request being answered |
| status_wr | input | 1 | Status write: clears valid, dirty and error |
| status_valid | output | NUM_BANKS | Row-valid bit of each bank |
| status_dirty | output | NUM_BANKS | Row-dirty bit of each bank |
| err_nack | output | 1 | Sticky unexpected-NAck flag |

## Verification
The bench keeps the default geometry of eight 1 MiB banks. It shortens the waits to CLEAN_WAIT=3 and DIRTY_WAIT=6. These two distinct, small values make it cheap to tell a clean miss from a dirty miss by pred_wait alone. They also let the bench count every busy cycle of a miss and let every wait run out between table entries. With the short waits, the bench can also land a request inside the busy window of a bank and then confirm, by a later hit prediction, that the open row survived.

// File: rtl/brt_pkg.sv
package brt_pkg;

  typedef enum logic [1:0] {
    KIND_HIT        = 2'd0,
    KIND_MISS_CLEAN = 2'd1,
    KIND_MISS_DIRTY = 2'd2
  } pred_kind_t;

endpackage

// File: rtl/brt_addr_split.sv
module brt_addr_split #(
  parameter int ADDR_W    = 26,
  parameter int BANK_LSB  = 20,
  parameter int ROW_LSB   = 11,
  parameter int NUM_BANKS = 8,
  localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ROW_W    = BANK_LSB - ROW_LSB,
  localparam int UPPER_W  = ADDR_W - BANK_LSB
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              tracked_o,
  output logic [IDX_W-1:0]  bank_o,
  output logic [ROW_W-1:0]  row_o
);

  logic [UPPER_W-1:0] upper;
  logic               unused_col_bits;

  always_comb begin
    upper           = addr_i[ADDR_W-1:BANK_LSB];
    tracked_o       = (upper < UPPER_W'(NUM_BANKS));
    bank_o          = addr_i[BANK_LSB +: IDX_W];
    row_o           = addr_i[BANK_LSB-1:ROW_LSB];
    unused_col_bits = ^addr_i[ROW_LSB-1:0];
  end

endmodule

// File: rtl/brt_bank_slot.sv
module brt_bank_slot
  import brt_pkg::*;
#(
  parameter int ROW_W      = 9,
  parameter int CLEAN_WAIT = 10,
  parameter int DIRTY_WAIT = 16,
  localparam int WAIT_W    = $clog2(DIRTY_WAIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_en,
  input  logic             issue_wr,
  input  logic [ROW_W-1:0] probe_row,
  input  logic             resp_en,
  input  logic             clear_all,
  output logic             valid_o,
  output logic             dirty_o,
  output logic             busy_o,
  output logic             expect_o,
  output pred_kind_t       kind_o
);

  logic              valid_q, valid_n;
  logic              dirty_q, dirty_n;
  logic              expect_q, expect_n;
  logic [ROW_W-1:0]  row_q;
  logic [WAIT_W-1:0] cnt_q, cnt_n;
  logic              accept, is_hit, row_ld, state_en;

  always_comb begin
    is_hit = valid_q && (row_q == probe_row);
    if (is_hit)       kind_o = KIND_HIT;
    else if (dirty_q) kind_o = KIND_MISS_DIRTY;
    else              kind_o = KIND_MISS_CLEAN;
  end

  always_comb begin
    accept   = issue_en && (cnt_q == '0);
    valid_n  = valid_q;
    dirty_n  = dirty_q;
    expect_n = expect_q;
    row_ld   = 1'b0;
    cnt_n    = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    if (resp_en) expect_n = 1'b0;
    if (accept) begin
      if (is_hit) begin
        dirty_n = dirty_q | issue_wr;
      end else begin
        row_ld   = 1'b1;
        valid_n  = 1'b1;
        dirty_n  = 1'b0;
        expect_n = 1'b1;
        cnt_n    = dirty_q ? WAIT_W'(DIRTY_WAIT) : WAIT_W'(CLEAN_WAIT);
      end
    end
    if (clear_all) begin
      valid_n = 1'b0;
      dirty_n = 1'b0;
    end
    state_en = accept || resp_en || clear_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      dirty_q  <= 1'b0;
      expect_q <= 1'b0;
    end else if (state_en) begin
      valid_q  <= valid_n;
      dirty_q  <= dirty_n;
      expect_q <= expect_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_q <= '0;
    else if (row_ld) row_q <= probe_row;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign valid_o  = valid_q;
  assign dirty_o  = dirty_q;
  assign busy_o   = (cnt_q != '0);
  assign expect_o = expect_q;

endmodule

// File: rtl/brt_nack_monitor.sv
module brt_nack_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic resp_valid,
  input  logic resp_ack,
  input  logic resp_tracked,
  input  logic resp_expected,
  input  logic clear,
  output logic err_o
);

  logic err_q, err_n, err_en, surprise;

  always_comb begin
    surprise = resp_valid && !resp_ack && !(resp_tracked && resp_expected);
    err_en   = clear || surprise;
    err_n    = clear ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_n;
  end

  assign err_o = err_q;

endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
  import brt_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int NUM_BANKS  = 8,
  parameter int BANK_LSB   = 20,
  parameter int ROW_LSB    = 11,
  parameter int CLEAN_WAIT = 10,
  parameter int DIRTY_WAIT = 16,
  localparam int WAIT_W    = $clog2(DIRTY_WAIT + 1),
  localparam int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ROW_W     = BANK_LSB - ROW_LSB
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 pred_tracked,
  output logic                 pred_hit,
  output logic [WAIT_W-1:0]    pred_wait,
  output logic                 bank_busy,
  input  logic                 resp_valid,
  input  logic                 resp_ack,
  input  logic [ADDR_W-1:0]    resp_addr,
  input  logic                 status_wr,
  output logic [NUM_BANKS-1:0] status_valid,
  output logic [NUM_BANKS-1:0] status_dirty,
  output logic                 err_nack
);

  logic             req_tracked, resp_tracked;
  logic [IDX_W-1:0] req_bank, resp_bank;
  logic [ROW_W-1:0] req_row, resp_row_unused;

  logic [NUM_BANKS-1:0] busy_vec, expect_vec;
  pred_kind_t           kind_vec [NUM_BANKS];
  pred_kind_t           kind_sel;
  logic                 resp_expected;

  brt_addr_split #(
    .ADDR_W(ADDR_W), .BANK_LSB(BANK_LSB), .ROW_LSB(ROW_LSB), .NUM_BANKS(NUM_BANKS)
  ) u_req_split (
    .addr_i(req_addr), .tracked_o(req_tracked), .bank_o(req_bank), .row_o(req_row)
  );

  brt_addr_split #(
    .ADDR_W(ADDR_W), .BANK_LSB(BANK_LSB), .ROW_LSB(ROW_LSB), .NUM_BANKS(NUM_BANKS)
  ) u_resp_split (
    .addr_i(resp_addr), .tracked_o(resp_tracked), .bank_o(resp_bank), .row_o(resp_row_unused)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic issue_here, resp_here;
    assign issue_here = req_valid && req_tracked && (req_bank == IDX_W'(g));
    assign resp_here  = resp_valid && resp_tracked && (resp_bank == IDX_W'(g));

    brt_bank_slot #(
      .ROW_W(ROW_W), .CLEAN_WAIT(CLEAN_WAIT), .DIRTY_WAIT(DIRTY_WAIT)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue_en  (issue_here),
      .issue_wr  (req_write),
      .probe_row (req_row),
      .resp_en   (resp_here),
      .clear_all (status_wr),
      .valid_o   (status_valid[g]),
      .dirty_o   (status_dirty[g]),
      .busy_o    (busy_vec[g]),
      .expect_o  (expect_vec[g]),
      .kind_o    (kind_vec[g])
    );
  end

  always_comb begin
    kind_sel      = kind_vec[req_bank];
    resp_expected = expect_vec[resp_bank];
    pred_tracked  = req_tracked;
    pred_hit      = req_tracked && (kind_sel == KIND_HIT);
    bank_busy     = req_tracked && busy_vec[req_bank];
    pred_wait     = '0;
    if (req_tracked) begin
      case (kind_sel)
        KIND_MISS_CLEAN: pred_wait = WAIT_W'(CLEAN_WAIT);
        KIND_MISS_DIRTY: pred_wait = WAIT_W'(DIRTY_WAIT);
        default:         pred_wait = '0;
      endcase
    end
  end

  brt_nack_monitor u_nack (
    .clk           (clk),
    .rst_n         (rst_n),
    .resp_valid    (resp_valid),
    .resp_ack      (resp_ack),
    .resp_tracked  (resp_tracked),
    .resp_expected (resp_expected),
    .clear         (status_wr),
    .err_o         (err_nack)
  );

endmodule

// File: rtl/brt_checker.sv
module brt_checker #(
  parameter int ADDR_W     = 26,
  parameter int NUM_BANKS  = 8,
  parameter int BANK_LSB   = 20,
  parameter int CLEAN_WAIT = 10,
  parameter int DIRTY_WAIT = 16,
  localparam int WAIT_W    = $clog2(DIRTY_WAIT + 1),
  localparam int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [ADDR_W-1:0]    req_addr,
  input logic                 pred_tracked,
  input logic                 pred_hit,
  input logic [WAIT_W-1:0]    pred_wait,
  input logic                 bank_busy,
  input logic                 resp_valid,
  input logic                 resp_ack,
  input logic                 status_wr,
  input logic [NUM_BANKS-1:0] status_valid,
  input logic [NUM_BANKS-1:0] status_dirty,
  input logic [NUM_BANKS-1:0] busy_vec,
  input logic                 err_nack
);

  logic [NUM_BANKS-1:0] sel_oh;
  logic                 issued;

  always_comb begin
    sel_oh = '0;
    sel_oh[req_addr[BANK_LSB +: IDX_W]] = pred_tracked;
    issued = req_valid && pred_tracked && !bank_busy && !status_wr;
  end

  assert_untracked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_tracked |-> (!pred_hit && pred_wait == '0 && !bank_busy));

  assert_untracked_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pred_tracked && !status_wr) |=> ($stable(status_valid) && $stable(status_dirty)));

  assert_write_hit_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issued && pred_hit && req_write) |=> ((status_dirty & $past(sel_oh)) == $past(sel_oh)));

  assert_miss_opens_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issued && !pred_hit) |=> (((status_valid & $past(sel_oh)) == $past(sel_oh)) &&
                              ((status_dirty & $past(sel_oh)) == '0)));

  assert_miss_wait_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_tracked && !pred_hit) |-> (pred_wait == WAIT_W'(CLEAN_WAIT) || pred_wait == WAIT_W'(DIRTY_WAIT)));

  assert_miss_goes_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issued && !pred_hit) |=> ((busy_vec & $past(sel_oh)) != '0));

  assert_busy_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bank_busy && !status_wr) |=> ($stable(status_valid) && $stable(status_dirty)));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_nack && !status_wr) |=> err_nack);

  assert_ack_no_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_nack && !(resp_valid && !resp_ack)) |=> !err_nack);

  assert_clear_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
    status_wr |=> (status_valid == '0 && status_dirty == '0 && !err_nack));

endmodule

bind bank_row_tracker brt_checker #(
  .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_LSB(BANK_LSB),
  .CLEAN_WAIT(CLEAN_WAIT), .DIRTY_WAIT(DIRTY_WAIT)
) u_brt_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .pred_tracked(pred_tracked), .pred_hit(pred_hit),
  .pred_wait(pred_wait), .bank_busy(bank_busy), .resp_valid(resp_valid),
  .resp_ack(resp_ack), .status_wr(status_wr), .status_valid(status_valid),
  .status_dirty(status_dirty), .busy_vec(busy_vec), .err_nack(err_nack)
);

// File: tb/bank_row_tracker_bench.sv
module bank_row_tracker_bench;

  localparam int AW    = 26;
  localparam int NB    = 8;
  localparam int CW    = 3;
  localparam int DW    = 6;
  localparam int WW    = $clog2(DW + 1);
  localparam int NVEC  = 11;

  logic          clk, rst_n;
  logic          req_valid, req_write, resp_valid, resp_ack, status_wr;
  logic [AW-1:0] req_addr, resp_addr;
  logic          pred_tracked, pred_hit, bank_busy, err_nack;
  logic [WW-1:0] pred_wait;
  logic [NB-1:0] status_valid, status_dirty;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bank_row_tracker #(
    .ADDR_W(AW), .NUM_BANKS(NB), .CLEAN_WAIT(CW), .DIRTY_WAIT(DW)
  ) u_bank_row_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .pred_tracked(pred_tracked), .pred_hit(pred_hit),
    .pred_wait(pred_wait), .bank_busy(bank_busy), .resp_valid(resp_valid),
    .resp_ack(resp_ack), .resp_addr(resp_addr), .status_wr(status_wr),
    .status_valid(status_valid), .status_dirty(status_dirty), .err_nack(err_nack)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {write, addr[25:0], tracked, hit, wait[3:0], valid_after[7:0], dirty_after[7:0]}
  localparam logic [48:0] VECS [NVEC] = '{
    {1'b0, 26'h0000000, 1'b1, 1'b0, 4'd3, 8'h01, 8'h00},
    {1'b0, 26'h0000400, 1'b1, 1'b1, 4'd0, 8'h01, 8'h00},
    {1'b1, 26'h0000010, 1'b1, 1'b1, 4'd0, 8'h01, 8'h01},
    {1'b0, 26'h0000800, 1'b1, 1'b0, 4'd6, 8'h01, 8'h00},
    {1'b0, 26'h0000800, 1'b1, 1'b1, 4'd0, 8'h01, 8'h00},
    {1'b1, 26'h01FF800, 1'b1, 1'b0, 4'd3, 8'h03, 8'h00},
    {1'b1, 26'h01FF800, 1'b1, 1'b1, 4'd0, 8'h03, 8'h02},
    {1'b0, 26'h07FF800, 1'b1, 1'b0, 4'd3, 8'h83, 8'h02},
    {1'b0, 26'h0000800, 1'b1, 1'b1, 4'd0, 8'h83, 8'h02},
    {1'b1, 26'h0800000, 1'b0, 1'b0, 4'd0, 8'h83, 8'h02},
    {1'b1, 26'h01FF000, 1'b1, 1'b0, 4'd6, 8'h83, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_resp(input logic [AW-1:0] a, input logic ack);
    @(negedge clk);
    resp_addr  = a;
    resp_ack   = ack;
    resp_valid = 1'b1;
    @(negedge clk);
    resp_valid = 1'b0;
  endtask

  task automatic pulse_status_wr();
    @(negedge clk);
    status_wr = 1'b1;
    @(negedge clk);
    status_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    resp_valid = 1'b0; resp_ack = 1'b1; resp_addr = '0; status_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 status_valid", 32'(status_valid), 32'h0);
    chk("R1 status_dirty", 32'(status_dirty), 32'h0);
    chk("R1 err_nack", 32'(err_nack), 32'h0);
    chk("R1 bank_busy", 32'(bank_busy), 32'h0);

    // table walk: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      req_write = VECS[i][48];
      req_addr  = VECS[i][47:22];
      #1;
      chk($sformatf("vec%0d R9 pred_tracked", i), 32'(pred_tracked), 32'(VECS[i][21]));
      chk($sformatf("vec%0d R3 R2 pred_hit", i), 32'(pred_hit), 32'(VECS[i][20]));
      chk($sformatf("vec%0d R4 R5 pred_wait", i), 32'(pred_wait), 32'(VECS[i][19:16]));
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (8) @(negedge clk);
      chk($sformatf("vec%0d R4 R2 status_valid", i), 32'(status_valid), 32'(VECS[i][15:8]));
      chk($sformatf("vec%0d R6 status_dirty", i), 32'(status_dirty), 32'(VECS[i][7:0]));
    end

    // R10: expected NAck on bank 1 (miss from last vector pending)
    send_resp(26'h0100000, 1'b0);
    chk("R10 expected nack no err", 32'(err_nack), 32'h0);
    send_resp(26'h0100000, 1'b0);
    chk("R10 second nack sets err", 32'(err_nack), 32'h1);
    @(negedge clk);
    chk("R10 err sticky", 32'(err_nack), 32'h1);

    // R11 status write clears
    pulse_status_wr();
    chk("R11 valid cleared", 32'(status_valid), 32'h0);
    chk("R11 dirty cleared", 32'(status_dirty), 32'h0);
    chk("R11 err cleared", 32'(err_nack), 32'h0);

    // R10 ack never sets, untracked nack does
    send_resp(26'h0000000, 1'b1);
    chk("R10 ack no err", 32'(err_nack), 32'h0);
    send_resp(26'h0900000, 1'b0);
    chk("R10 untracked nack sets err", 32'(err_nack), 32'h1);
    pulse_status_wr();

    // R7 busy window, R8 request while busy ignored
    @(negedge clk);
    req_addr = 26'h0100000; req_write = 1'b0;
    #1;
    chk("R4 miss on cleared bank", 32'(pred_wait), 32'(CW));
    req_valid = 1'b1;
    @(negedge clk);
    chk("R7 busy cycle 1", 32'(bank_busy), 32'h1);
    req_addr = 26'h0100800; req_write = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 busy cycle 2", 32'(bank_busy), 32'h1);
    @(negedge clk);
    chk("R7 busy cycle 3", 32'(bank_busy), 32'h1);
    @(negedge clk);
    chk("R7 busy ends", 32'(bank_busy), 32'h0);
    req_addr = 26'h0100000; req_write = 1'b0;
    #1;
    chk("R8 row kept after ignored request", 32'(pred_hit), 32'h1);
    chk("R8 dirty untouched", 32'(status_dirty), 32'h0);
    chk("R8 valid bank1 only", 32'(status_valid), 32'h02);

    // R1 reset mid-run
    send_resp(26'h0900000, 1'b0);
    chk("R10 err before reset", 32'(err_nack), 32'h1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset clears valid", 32'(status_valid), 32'h0);
    chk("R1 reset clears err", 32'(err_nack), 32'h0);
    req_addr = 26'h0100000;
    #1;
    chk("R1 reset miss prediction", 32'(pred_hit), 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule